// File: doc/BRIEF.md
# Instruction fetch address generator with circular return stack

This block produces the instruction fetch address for a small two-stage Harvard core. It keeps a 13-bit program counter that advances by one per fetch. The counter can also be reloaded from four sources: a jump or call target, a write to its low byte, a return from the stack, or the interrupt vector. It holds an eight-entry return stack with no flags. Calls and interrupts push onto it, and the three return-type instructions pop from it. When the stack is full, the oldest entry is overwritten without any indication.

Targets taken from the instruction carry only 11 bits, which gives 2K-word pages. The upper counter bits come from a separate 5-bit latch register that software loads ahead of time. Whenever the counter is reloaded out of sequence, the block raises a one-cycle flush. The decoder uses the flush to discard the instruction it has already fetched, so that such instructions cost two cycles. The decoder resolves the request inputs as single-cycle strobes, and the block applies a fixed priority when several arrive together.

Top module: `pcgen_top`

## Requirements
- R1: While rst_ni is low and on the first cycle after release, pc_o is 0x0000, fetch_addr_o is 0x000 and flush_o is 0.
- R2: adv_i alone increments pc_o by one at the next clock edge. The count wraps from 0x1FFF to 0x0000.
- R3: fetch_addr_o always equals the low 12 bits of pc_o, so bit 12 does not appear on the fetch address.
- R4: jump_i loads pc_o with {latch[4:3], target_i[10:0]}, where latch is the 5-bit value last written through latch_we_i/latch_d_i.
- R5: call_i loads pc_o in the same way as jump_i and pushes the pre-load value of pc_o onto the stack. A later ret_i restores that value.
- R6: low_we_i loads pc_o with {latch[4:0], low_d_i[7:0]}.
- R7: irq_i pushes the current pc_o and loads pc_o with 0x0004.
- R8: ret_i pops the most recent stack entry into pc_o. Pops return entries in the reverse order of their pushes.
- R9: The stack holds 8 entries. After nine pushes, eight pops return the 9th through 2nd pushed values, because the ninth push overwrote the first.
- R10: A pop beyond the stored entries wraps the pointer and returns the stale entry it then selects. After nine pushes and eight pops, a ninth pop returns the ninth pushed value again.
- R11: flush_o is 1 for exactly the one cycle after any load by irq_i, ret_i, call_i, jump_i or low_we_i. It is 0 after an advance or an idle cycle.
- R12: Simultaneous requests resolve in the order irq_i > ret_i > call_i > jump_i > low_we_i > adv_i. Only the winning request takes effect, and it causes at most one push or one pop.
- R13: A latch write takes effect for loads in later cycles. A load in the same cycle uses the previous latch value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adv_i | input | 1 | Sequential advance |
| jump_i | input | 1 | Load from instruction target |
| call_i | input | 1 | Load from target and push return address |
| ret_i | input | 1 | Return-type instruction, pop stack |
| irq_i | input | 1 | Interrupt taken, push and vector |
| target_i | input | 11 | Target field from the instruction |
| low_we_i | input | 1 | Write the low PC byte |
| low_d_i | input | 8 | Data for the low PC byte |
| latch_we_i | input | 1 | Write the PC latch register |
| latch_d_i | input | 5 | Data for the PC latch register |
| pc_o | output | 13 | Program counter |
| fetch_addr_o | output | 12 | Program memory fetch address |
| flush_o | output | 1 | Discard the already fetched instruction |

## Verification
A stale or misaligned stack pointer appears at pc_o on the first return after the fault, as a return address that does not match the matching push. A wrong overwrite slot shows up only once a ninth push has wrapped the stack and pops then walk back through every entry. Errors in page composition or priority appear in pc_o and flush_o one edge after the offending request. For this reason every load is checked on the cycle directly after it, and the stack is exercised through a complete wrap and one extra pop.

// File: rtl/pcgen_pkg.sv
package pcgen_pkg;
  localparam int unsigned PC_W   = 13;
  localparam int unsigned MEM_AW = 12;
  localparam int unsigned TGT_W  = 11;
  localparam int unsigned LAT_W  = 5;
  localparam int unsigned STK_D  = 8;
  localparam logic [PC_W-1:0] RST_VEC = 13'h0000;
  localparam logic [PC_W-1:0] IRQ_VEC = 13'h0004;

  typedef enum logic [2:0] {
    SEL_HOLD, SEL_SEQ, SEL_LOW, SEL_JMP, SEL_RET, SEL_VEC
  } pc_sel_e;
endpackage

// File: rtl/pcgen_stack.sv
module pcgen_stack #(
  parameter int unsigned W = 13,
  parameter int unsigned D = 8   // power of two, pointer wraps freely
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_d_i,
  output logic [W-1:0] top_o
);
  localparam int unsigned PTR_W = $clog2(D);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] rd_idx;
  logic [W-1:0]     mem_q [D];

  assign rd_idx = ptr_q - 1'b1;
  assign top_o  = mem_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (push_i) ptr_q <= ptr_q + 1'b1;
    else if (pop_i)  ptr_q <= ptr_q - 1'b1;
  end

  for (genvar g = 0; g < D; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[g] <= '0;
      else if (push_i && ptr_q == PTR_W'(g))         mem_q[g] <= push_d_i;
    end
  end

  // R12
  push_pop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
  // R9
  push_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> ptr_q == $past(ptr_q) + 1'b1);
  // R8
  pop_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> ptr_q == $past(ptr_q) - 1'b1);
  // R8
  push_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(push_d_i));
endmodule

// File: rtl/pcgen_next.sv
module pcgen_next
  import pcgen_pkg::*;
#(
  parameter int unsigned PW = PC_W,
  parameter int unsigned TW = TGT_W,
  parameter int unsigned LW = LAT_W
) (
  input  logic          adv_i,
  input  logic          jump_i,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          irq_i,
  input  logic          low_we_i,
  input  logic [TW-1:0] target_i,
  input  logic [7:0]    low_d_i,
  input  logic [LW-1:0] latch_i,
  input  logic [PW-1:0] pc_i,
  input  logic [PW-1:0] stack_top_i,
  output logic [PW-1:0] pc_d_o,
  output logic          push_o,
  output logic          pop_o,
  output logic          nonseq_o
);
  localparam int unsigned PG_W = PW - TW;

  pc_sel_e sel;

  always_comb begin
    if      (irq_i)           sel = SEL_VEC;
    else if (ret_i)           sel = SEL_RET;
    else if (call_i || jump_i) sel = SEL_JMP;
    else if (low_we_i)        sel = SEL_LOW;
    else if (adv_i)           sel = SEL_SEQ;
    else                      sel = SEL_HOLD;
  end

  always_comb begin
    unique case (sel)
      SEL_VEC:  pc_d_o = IRQ_VEC;
      SEL_RET:  pc_d_o = stack_top_i;
      SEL_JMP:  pc_d_o = {latch_i[LW-1 -: PG_W], target_i};
      SEL_LOW:  pc_d_o = {latch_i, low_d_i};
      SEL_SEQ:  pc_d_o = pc_i + 1'b1;
      default:  pc_d_o = pc_i;
    endcase
  end

  assign push_o   = irq_i || (!ret_i && call_i);
  assign pop_o    = !irq_i && ret_i;
  assign nonseq_o = sel inside {SEL_VEC, SEL_RET, SEL_JMP, SEL_LOW};
endmodule

// File: rtl/pcgen_top.sv
module pcgen_top
  import pcgen_pkg::*;
#(
  parameter int unsigned PW = PC_W,
  parameter int unsigned AW = MEM_AW,
  parameter int unsigned TW = TGT_W,
  parameter int unsigned LW = LAT_W,
  parameter int unsigned SD = STK_D
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          jump_i,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          irq_i,
  input  logic [TW-1:0] target_i,
  input  logic          low_we_i,
  input  logic [7:0]    low_d_i,
  input  logic          latch_we_i,
  input  logic [LW-1:0] latch_d_i,
  output logic [PW-1:0] pc_o,
  output logic [AW-1:0] fetch_addr_o,
  output logic          flush_o
);
  logic [PW-1:0] pc_q, pc_d, stack_top;
  logic [LW-1:0] latch_q;
  logic          push, pop, nonseq, flush_q;

  pcgen_next #(.PW(PW), .TW(TW), .LW(LW)) next_i (
    .adv_i, .jump_i, .call_i, .ret_i, .irq_i, .low_we_i,
    .target_i, .low_d_i,
    .latch_i     (latch_q),
    .pc_i        (pc_q),
    .stack_top_i (stack_top),
    .pc_d_o      (pc_d),
    .push_o      (push),
    .pop_o       (pop),
    .nonseq_o    (nonseq)
  );

  pcgen_stack #(.W(PW), .D(SD)) stack_i (
    .clk_i, .rst_ni,
    .push_i   (push),
    .pop_i    (pop),
    .push_d_i (pc_q),
    .top_o    (stack_top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RST_VEC;
      latch_q <= '0;
      flush_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      flush_q <= nonseq;
      if (latch_we_i) latch_q <= latch_d_i;
    end
  end

  assign pc_o         = pc_q;
  assign fetch_addr_o = pc_q[AW-1:0];
  assign flush_o      = flush_q;

  // R7
  irq_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> pc_o == IRQ_VEC);
  // R11
  flush_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i || ret_i || call_i || jump_i || low_we_i) |=> flush_o);
  // R11
  flush_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_i || ret_i || call_i || jump_i || low_we_i) |=> !flush_o);
  // R2
  seq_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !(irq_i || ret_i || call_i || jump_i || low_we_i))
      |=> pc_o == $past(pc_o) + 1'b1);
  // R4
  jump_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && !irq_i && !ret_i)
      |=> pc_o[TW-1:0] == $past(target_i) && pc_o[PW-1:TW] == $past(latch_q[LW-1 -: PW-TW]));
  // R3
  fetch_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_addr_o == pc_o[AW-1:0]);
endmodule

// File: tb/pcgen_top_tb.sv
module pcgen_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv = 0, jump = 0, call = 0, ret = 0, irq = 0, low_we = 0, latch_we = 0;
  logic [10:0] target = '0;
  logic [7:0]  low_d = '0;
  logic [4:0]  latch_d = '0;
  logic [12:0] pc;
  logic [11:0] faddr;
  logic        flush;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pcgen_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .jump_i(jump), .call_i(call),
    .ret_i(ret), .irq_i(irq), .target_i(target), .low_we_i(low_we), .low_d_i(low_d),
    .latch_we_i(latch_we), .latch_d_i(latch_d), .pc_o(pc), .fetch_addr_o(faddr),
    .flush_o(flush)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    adv = 0; jump = 0; call = 0; ret = 0; irq = 0; low_we = 0; latch_we = 0;
  endtask

  // inputs set after a negedge are taken at the next posedge; outputs read at the following negedge
  task automatic tick();
    @(negedge clk);
    idle_all();
  endtask

  task automatic set_latch(logic [4:0] v);
    latch_we = 1; latch_d = v; tick();
  endtask

  task automatic set_low(logic [7:0] v);
    low_we = 1; low_d = v; tick();
  endtask

  task automatic t_reset();
    chk("R1 pc in reset", pc, 13'h0);
    chk("R1 flush in reset", flush, 0);
    @(negedge clk); rst_n = 1;
    tick();
    chk("R1 pc after release", pc, 13'h0);
    chk("R1 fetch after release", faddr, 12'h0);
    chk("R1 flush after release", flush, 0);
  endtask

  task automatic t_seq();
    adv = 1; tick();
    chk("R2 advance", pc, 13'h1);
    chk("R11 no flush on advance", flush, 0);
    adv = 1; tick();
    chk("R2 advance again", pc, 13'h2);
    tick();
    chk("R2 hold when idle", pc, 13'h2);
  endtask

  task automatic t_low_wrap();
    set_latch(5'h1F);
    chk("R11 no flush on latch write", flush, 0);
    set_low(8'hFF);
    chk("R6 low write", pc, 13'h1FFF);
    chk("R3 top bit dropped", faddr, 12'hFFF);
    chk("R11 flush after low write", flush, 1);
    adv = 1; tick();
    chk("R2 wrap to zero", pc, 13'h0);
    chk("R11 flush one cycle only", flush, 0);
  endtask

  task automatic t_jump();
    set_latch(5'h0B);  // bits 4:3 = 01
    jump = 1; target = 11'h123; tick();
    chk("R4 jump page", pc, 13'h0923);
    chk("R11 flush after jump", flush, 1);
    // R13: same-cycle latch write does not affect this load
    latch_we = 1; latch_d = 5'h10; jump = 1; target = 11'h055; tick();
    chk("R13 old latch used", pc, 13'h0855);
    jump = 1; target = 11'h055; tick();
    chk("R13 new latch used", pc, 13'h1055);
  endtask

  task automatic t_call_ret();
    set_latch(5'h02);
    set_low(8'h40);  // pc 0x240
    call = 1; target = 11'h7F0; tick();
    chk("R5 call target", pc, 13'h07F0);
    adv = 1; tick();
    ret = 1; tick();
    chk("R5 return to caller", pc, 13'h0240);
    chk("R11 flush after return", flush, 1);
  endtask

  task automatic t_irq();
    set_latch(5'h03);
    set_low(8'h77);  // pc 0x377
    irq = 1; jump = 1; ret = 1; target = 11'h111; tick();
    chk("R7 vector", pc, 13'h0004);
    chk("R12 irq wins", flush, 1);
    ret = 1; tick();
    chk("R7 pushed pc restored", pc, 13'h0377);
    // R12: ret beats call, and call does not push
    set_low(8'h11);  // pc 0x311
    call = 1; target = 11'h020; tick();  // push 0x311
    call = 1; ret = 1; target = 11'h030; tick();
    chk("R12 ret over call", pc, 13'h0311);
    // R12: call beats low write
    call = 1; low_we = 1; low_d = 8'h99; target = 11'h044; tick();
    chk("R12 call over low write", pc, 13'h0044);
    ret = 1; tick();
    chk("R12 call pushed once", pc, 13'h0311);
    // R12: low write beats advance
    low_we = 1; low_d = 8'h22; adv = 1; tick();
    chk("R12 low over advance", pc, 13'h0322);
  endtask

  task automatic t_wrap_stack();
    for (int k = 0; k < 9; k++) begin
      set_latch(5'h01);
      set_low(8'(k));
      set_latch(5'h00);
      call = 1; target = 11'h7FF; tick();
    end
    for (int k = 8; k >= 1; k--) begin
      ret = 1; tick();
      chk("R9 pop order", pc, 13'h100 + 13'(k));
    end
    ret = 1; tick();
    chk("R10 empty pop stale entry", pc, 13'h108);
  endtask

  initial begin
    t_reset();
    t_seq();
    t_low_wrap();
    t_jump();
    t_call_ret();
    t_irq();
    t_wrap_stack();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule